// File: doc/BRIEF.md
# Two-Antenna Space-Time Block Combiner with 16-QAM Slicer

This block sits on one subcarrier of a two-receive-antenna link that uses a rate-one, two-slot space-time block code. The transmitter sends `s0` from antenna 0 and `s1` from antenna 1 in the first slot. In the second slot it sends `-conj(s1)` from antenna 0 and `conj(s0)` from antenna 1. The block takes one complex sample per receive antenna per slot. It holds the first-slot pair and combines it with the second-slot pair, using four complex channel gains and conjugate cross-terms. The result is a maximum-ratio estimate of both transmitted symbols.

Each combined estimate is saturated to a declared output width. It is then cut to the nearest 16-QAM point on the odd-integer grid {-3, -1, +1, +3} per component, and a 4-bit label is produced. Channel gains are named by path: `h0` runs from tx0 to rx0, `h1` from tx1 to rx0, `h2` from tx0 to rx1 and `h3` from tx1 to rx1. Scaling the estimate by channel power lies outside the block, and so do channel estimation and the FFT. The slicer therefore sees the raw combined value.

Top module: `stc2x2_combiner`

## Requirements
- R1: Accepted samples (a cycle with `in_valid` high) alternate between slot 0 and slot 1, and the first accepted sample after reset is slot 0. Idle cycles between the two slots of a pair do not break the pairing, and they do not disturb the held slot-0 samples.
- R2: While `rst_n` is low, and after it is released until the first result, `out_valid` is 0 and every estimate and label output is 0. A slot-0 sample accepted before a reset is discarded, so the next accepted sample is slot 0 again.
- R3: The s0 estimate equals conj(h0)·r0 + h1·conj(r1) + conj(h2)·r2 + h3·conj(r3). Here r0 and r1 are the rx0 samples of slots 0 and 1, and r2 and r3 are the rx1 samples of slots 0 and 1.
- R4: The s1 estimate equals conj(h1)·r0 − h0·conj(r1) + conj(h3)·r2 − h2·conj(r3).
- R5: The channel gains are taken only in the slot-1 cycle. Gain values present with a slot-0 sample or on idle cycles have no effect.
- R6: Products and sums are formed at full precision. Each estimate component is then saturated to a signed `OW`-bit value: −2^(OW−1) to 2^(OW−1)−1.
- R7: Each saturated component v is sliced with ties resolved upward. v < −2 gives −3, −2 ≤ v < 0 gives −1, 0 ≤ v < 2 gives +1, and v ≥ 2 gives +3, so any value beyond ±3 clips to the outer level.
- R8: Label bits [3:2] code the real level and bits [1:0] the imaginary level, with 00 = −3, 01 = −1, 11 = +1 and 10 = +3. With a single unit-magnitude channel gain and noise-free samples, the labels equal the transmitted labels.
- R9: `out_valid` is a one-cycle pulse. It is seen two clock edges after the edge that accepts the slot-1 sample, and there is exactly one result per pair, including when pairs arrive back to back.
- R10: Between pulses of `out_valid` the estimate and label outputs hold their last values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, deasserted synchronously to clk |
| in_valid | input | 1 | Sample present on this cycle |
| rx0_re | input | SW | Receive antenna 0 sample, real part |
| rx0_im | input | SW | Receive antenna 0 sample, imaginary part |
| rx1_re | input | SW | Receive antenna 1 sample, real part |
| rx1_im | input | SW | Receive antenna 1 sample, imaginary part |
| h0_re | input | HW | Gain tx0→rx0, real part |
| h0_im | input | HW | Gain tx0→rx0, imaginary part |
| h1_re | input | HW | Gain tx1→rx0, real part |
| h1_im | input | HW | Gain tx1→rx0, imaginary part |
| h2_re | input | HW | Gain tx0→rx1, real part |
| h2_im | input | HW | Gain tx0→rx1, imaginary part |
| h3_re | input | HW | Gain tx1→rx1, real part |
| h3_im | input | HW | Gain tx1→rx1, imaginary part |
| out_valid | output | 1 | Result pulse |
| s0_re | output | OW | Saturated s0 estimate, real part |
| s0_im | output | OW | Saturated s0 estimate, imaginary part |
| s1_re | output | OW | Saturated s1 estimate, real part |
| s1_im | output | OW | Saturated s1 estimate, imaginary part |
| s0_label | output | 4 | Hard-decision label of s0 |
| s1_label | output | 4 | Hard-decision label of s1 |

## Verification
The checker watches the slot phase on every cycle. It confirms that the phase flips on each accepted sample and holds otherwise. It also checks that a result pulse follows each slot-1 acceptance by exactly two edges, never lasts two cycles, and leaves the outputs frozen between pulses. A sample of the slicer's decision against the saturated value is checked there too. The arithmetic itself can only be shown by the bench's scenarios. These cover all 256 symbol pairs through several single-path and two-path channels, a grid of raw estimates across every slicing boundary, full-scale inputs that drive saturation, garbage gains on slot 0, stalls inside a pair, and a reset that falls between the two slots.

// File: rtl/stc_pkg.sv
package stc_pkg;

  // 2-bit level code used in each half of a label
  typedef enum logic [1:0] {
    LVL_NEG3 = 2'b00,
    LVL_NEG1 = 2'b01,
    LVL_POS3 = 2'b10,
    LVL_POS1 = 2'b11
  } lvl_e;

  localparam int N_TERMS = 4;  // received samples per pair (2 antennas x 2 slots)
  localparam int N_EST   = 2;  // symbols recovered per pair

endpackage

// File: rtl/stc_slot_ctrl.sv
// Tracks which slot the next accepted sample belongs to and holds the slot-0 samples.
module stc_slot_ctrl #(
  parameter int SW = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] rx0_re,
  input  logic signed [SW-1:0] rx0_im,
  input  logic signed [SW-1:0] rx1_re,
  input  logic signed [SW-1:0] rx1_im,
  output logic                 slot_q,
  output logic                 fire,
  output logic signed [SW-1:0] r0_re,
  output logic signed [SW-1:0] r0_im,
  output logic signed [SW-1:0] r2_re,
  output logic signed [SW-1:0] r2_im
);

  logic slot_d;
  logic hold_en;

  always_comb begin
    slot_d  = slot_q;
    hold_en = 1'b0;
    if (in_valid) begin
      slot_d  = ~slot_q;
      hold_en = ~slot_q;
    end
  end

  assign fire = in_valid & slot_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= 1'b0;
    end else begin
      slot_q <= slot_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      r0_re <= '0;
      r0_im <= '0;
      r2_re <= '0;
      r2_im <= '0;
    end else if (hold_en) begin
      r0_re <= rx0_re;
      r0_im <= rx0_im;
      r2_re <= rx1_re;
      r2_im <= rx1_im;
    end
  end

endmodule

// File: rtl/stc_cmul.sv
// Full-precision complex product with optional conjugation of either operand.
module stc_cmul #(
  parameter int AW     = 6,
  parameter int BW     = 6,
  parameter bit CONJ_A = 1'b0,
  parameter bit CONJ_B = 1'b0,
  localparam int PW    = AW + BW + 3
) (
  input  logic signed [AW-1:0] a_re,
  input  logic signed [AW-1:0] a_im,
  input  logic signed [BW-1:0] b_re,
  input  logic signed [BW-1:0] b_im,
  output logic signed [PW-1:0] p_re,
  output logic signed [PW-1:0] p_im
);

  localparam int MW = AW + BW + 2;

  logic signed [AW:0]   ar, ai;
  logic signed [BW:0]   br, bi;
  logic signed [MW-1:0] m_rr, m_ii, m_ri, m_ir;

  always_comb begin
    ar = {a_re[AW-1], a_re};
    br = {b_re[BW-1], b_re};
    if (CONJ_A) ai = -{a_im[AW-1], a_im};
    else        ai =  {a_im[AW-1], a_im};
    if (CONJ_B) bi = -{b_im[BW-1], b_im};
    else        bi =  {b_im[BW-1], b_im};
    m_rr = ar * br;
    m_ii = ai * bi;
    m_ri = ar * bi;
    m_ir = ai * br;
    p_re = {m_rr[MW-1], m_rr} - {m_ii[MW-1], m_ii};
    p_im = {m_ri[MW-1], m_ri} + {m_ir[MW-1], m_ir};
  end

endmodule

// File: rtl/stc_sat_slice.sv
// Saturates one estimate component to OW bits and picks its nearest odd level.
module stc_sat_slice
  import stc_pkg::*;
#(
  parameter int IW = 17,
  parameter int OW = 12
) (
  input  logic signed [IW-1:0] val_in,
  output logic signed [OW-1:0] val_sat,
  output lvl_e                 lvl
);

  generate
    if (IW > OW) begin : g_clip
      localparam logic signed [IW-1:0] HI_LIM = IW'((64'sd1 <<< (OW - 1)) - 64'sd1);
      localparam logic signed [IW-1:0] LO_LIM = -HI_LIM - IW'(1);
      always_comb begin
        if (val_in > HI_LIM)      val_sat = HI_LIM[OW-1:0];
        else if (val_in < LO_LIM) val_sat = LO_LIM[OW-1:0];
        else                      val_sat = val_in[OW-1:0];
      end
    end else begin : g_extend
      assign val_sat = OW'(val_in);
    end
  endgenerate

  localparam logic signed [OW-1:0] TWO  = OW'(2);
  localparam logic signed [OW-1:0] MTWO = -TWO;

  always_comb begin
    if (val_sat < MTWO)        lvl = LVL_NEG3;
    else if (val_sat < 0)      lvl = LVL_NEG1;
    else if (val_sat < TWO)    lvl = LVL_POS1;
    else                       lvl = LVL_POS3;
  end

endmodule

// File: rtl/stc2x2_combiner.sv
module stc2x2_combiner
  import stc_pkg::*;
#(
  parameter int SW = 6,
  parameter int HW = 6,
  parameter int OW = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic signed [SW-1:0] rx0_re,
  input  logic signed [SW-1:0] rx0_im,
  input  logic signed [SW-1:0] rx1_re,
  input  logic signed [SW-1:0] rx1_im,
  input  logic signed [HW-1:0] h0_re,
  input  logic signed [HW-1:0] h0_im,
  input  logic signed [HW-1:0] h1_re,
  input  logic signed [HW-1:0] h1_im,
  input  logic signed [HW-1:0] h2_re,
  input  logic signed [HW-1:0] h2_im,
  input  logic signed [HW-1:0] h3_re,
  input  logic signed [HW-1:0] h3_im,
  output logic                 out_valid,
  output logic signed [OW-1:0] s0_re,
  output logic signed [OW-1:0] s0_im,
  output logic signed [OW-1:0] s1_re,
  output logic signed [OW-1:0] s1_im,
  output logic [3:0]           s0_label,
  output logic [3:0]           s1_label
);

  localparam int PW   = HW + SW + 3;   // one complex product
  localparam int SUMW = PW + 2;        // sum of four products

  // ---------------- slot pairing ----------------
  logic                 slot_q;
  logic                 fire;
  logic signed [SW-1:0] r0_re, r0_im, r2_re, r2_im;

  stc_slot_ctrl #(.SW(SW)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .rx0_re   (rx0_re),
    .rx0_im   (rx0_im),
    .rx1_re   (rx1_re),
    .rx1_im   (rx1_im),
    .slot_q   (slot_q),
    .fire     (fire),
    .r0_re    (r0_re),
    .r0_im    (r0_im),
    .r2_re    (r2_re),
    .r2_im    (r2_im)
  );

  // operand arrays indexed by term / path
  logic signed [SW-1:0] r_re [N_TERMS];
  logic signed [SW-1:0] r_im [N_TERMS];
  logic signed [HW-1:0] g_re [N_TERMS];
  logic signed [HW-1:0] g_im [N_TERMS];

  always_comb begin
    r_re[0] = r0_re;   r_im[0] = r0_im;
    r_re[1] = rx0_re;  r_im[1] = rx0_im;
    r_re[2] = r2_re;   r_im[2] = r2_im;
    r_re[3] = rx1_re;  r_im[3] = rx1_im;
    g_re[0] = h0_re;   g_im[0] = h0_im;
    g_re[1] = h1_re;   g_im[1] = h1_im;
    g_re[2] = h2_re;   g_im[2] = h2_im;
    g_re[3] = h3_re;   g_im[3] = h3_im;
  end

  // ---------------- products ----------------
  // term t: gain conjugated on even t, sample conjugated on odd t;
  // estimate 0 pairs term t with path t, estimate 1 with path t^1.
  logic signed [PW-1:0] prod_re [N_EST][N_TERMS];
  logic signed [PW-1:0] prod_im [N_EST][N_TERMS];

  for (genvar k = 0; k < N_EST; k++) begin : g_est
    for (genvar t = 0; t < N_TERMS; t++) begin : g_term
      localparam int GI = (k == 0) ? t : (t ^ 1);
      stc_cmul #(
        .AW     (HW),
        .BW     (SW),
        .CONJ_A ((t % 2) == 0),
        .CONJ_B ((t % 2) == 1)
      ) u_mul (
        .a_re (g_re[GI]),
        .a_im (g_im[GI]),
        .b_re (r_re[t]),
        .b_im (r_im[t]),
        .p_re (prod_re[k][t]),
        .p_im (prod_im[k][t])
      );
    end
  end

  // ---------------- stage 1: product registers ----------------
  logic                 v1_q;
  logic signed [PW-1:0] prod_re_q [N_EST][N_TERMS];
  logic signed [PW-1:0] prod_im_q [N_EST][N_TERMS];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
    end else begin
      v1_q <= fire;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < N_EST; k++) begin
        for (int t = 0; t < N_TERMS; t++) begin
          prod_re_q[k][t] <= '0;
          prod_im_q[k][t] <= '0;
        end
      end
    end else if (fire) begin
      for (int k = 0; k < N_EST; k++) begin
        for (int t = 0; t < N_TERMS; t++) begin
          prod_re_q[k][t] <= prod_re[k][t];
          prod_im_q[k][t] <= prod_im[k][t];
        end
      end
    end
  end

  // ---------------- combine ----------------
  logic signed [SUMW-1:0] sum_re [N_EST];
  logic signed [SUMW-1:0] sum_im [N_EST];

  always_comb begin
    for (int k = 0; k < N_EST; k++) begin
      sum_re[k] = '0;
      sum_im[k] = '0;
      for (int t = 0; t < N_TERMS; t++) begin
        if (k == 1 && (t % 2) == 1) begin
          sum_re[k] = sum_re[k] - SUMW'(prod_re_q[k][t]);
          sum_im[k] = sum_im[k] - SUMW'(prod_im_q[k][t]);
        end else begin
          sum_re[k] = sum_re[k] + SUMW'(prod_re_q[k][t]);
          sum_im[k] = sum_im[k] + SUMW'(prod_im_q[k][t]);
        end
      end
    end
  end

  // ---------------- saturate and slice ----------------
  logic signed [OW-1:0] sat_v [N_EST][2];
  lvl_e                 lvl_v [N_EST][2];

  for (genvar k = 0; k < N_EST; k++) begin : g_ss
    for (genvar c = 0; c < 2; c++) begin : g_comp
      stc_sat_slice #(.IW(SUMW), .OW(OW)) u_ss (
        .val_in  ((c == 0) ? sum_re[k] : sum_im[k]),
        .val_sat (sat_v[k][c]),
        .lvl     (lvl_v[k][c])
      );
    end
  end

  // ---------------- stage 2: output registers ----------------
  logic signed [OW-1:0] s0_re_d, s0_im_d, s1_re_d, s1_im_d;
  logic [3:0]           s0_lab_d, s1_lab_d;

  always_comb begin
    s0_re_d  = sat_v[0][0];
    s0_im_d  = sat_v[0][1];
    s1_re_d  = sat_v[1][0];
    s1_im_d  = sat_v[1][1];
    s0_lab_d = {lvl_v[0][0], lvl_v[0][1]};
    s1_lab_d = {lvl_v[1][0], lvl_v[1][1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= v1_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s0_re    <= '0;
      s0_im    <= '0;
      s1_re    <= '0;
      s1_im    <= '0;
      s0_label <= '0;
      s1_label <= '0;
    end else if (v1_q) begin
      s0_re    <= s0_re_d;
      s0_im    <= s0_im_d;
      s1_re    <= s1_re_d;
      s1_im    <= s1_im_d;
      s0_label <= s0_lab_d;
      s1_label <= s1_lab_d;
    end
  end

endmodule

// File: rtl/stc2x2_combiner_chk.sv
module stc2x2_combiner_chk #(
  parameter int OW = 12
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 slot_q,
  input logic                 out_valid,
  input logic signed [OW-1:0] s0_re,
  input logic signed [OW-1:0] s0_im,
  input logic signed [OW-1:0] s1_re,
  input logic signed [OW-1:0] s1_im,
  input logic [3:0]           s0_label,
  input logic [3:0]           s1_label
);

  // R1
  slot_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> (slot_q != $past(slot_q)));

  // R1
  slot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(slot_q));

  // R9
  result_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid && slot_q, 2));

  // R9
  result_due_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_valid && slot_q, 2) |-> out_valid);

  // R9
  single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable({s0_re, s0_im, s1_re, s1_im, s0_label, s1_label}));

  // R8
  outer_pos_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (s0_re >= 2)) |-> (s0_label[3:2] == 2'b10));

  // R8
  outer_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && (s1_im < -2)) |-> (s1_label[1:0] == 2'b00));

endmodule

bind stc2x2_combiner stc2x2_combiner_chk #(.OW(OW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .slot_q    (slot_q),
  .out_valid (out_valid),
  .s0_re     (s0_re),
  .s0_im     (s0_im),
  .s1_re     (s1_re),
  .s1_im     (s1_im),
  .s0_label  (s0_label),
  .s1_label  (s1_label)
);

// File: tb/stc2x2_combiner_tb.sv
module stc2x2_combiner_tb;

  localparam int SW = 6;
  localparam int HW = 6;
  localparam int OW = 12;
  localparam int QN = 2048;
  localparam longint SMAX = (64'sd1 <<< (OW - 1)) - 1;
  localparam longint SMIN = -SMAX - 1;

  logic clk;
  logic rst_n;
  logic in_valid;
  logic signed [SW-1:0] rx0_re, rx0_im, rx1_re, rx1_im;
  logic signed [HW-1:0] h0_re, h0_im, h1_re, h1_im, h2_re, h2_im, h3_re, h3_im;
  logic out_valid;
  logic signed [OW-1:0] s0_re, s0_im, s1_re, s1_im;
  logic [3:0] s0_label, s1_label;

  stc2x2_combiner #(.SW(SW), .HW(HW), .OW(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid),
    .rx0_re(rx0_re), .rx0_im(rx0_im), .rx1_re(rx1_re), .rx1_im(rx1_im),
    .h0_re(h0_re), .h0_im(h0_im), .h1_re(h1_re), .h1_im(h1_im),
    .h2_re(h2_re), .h2_im(h2_im), .h3_re(h3_re), .h3_im(h3_im),
    .out_valid(out_valid), .s0_re(s0_re), .s0_im(s0_im),
    .s1_re(s1_re), .s1_im(s1_im), .s0_label(s0_label), .s1_label(s1_label)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int errs   = 0;
  int checks = 0;
  int cyc    = 0;
  bit done   = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // expected results
  longint ex_s0r [QN], ex_s0i [QN], ex_s1r [QN], ex_s1i [QN];
  int     ex_l0 [QN], ex_l1 [QN], ex_tx0 [QN], ex_tx1 [QN], ex_cyc [QN];
  int     wr = 0;
  int     rd = 0;

  // stimulus model
  int hr [4], hi [4], rr [4], ri [4];
  int tx0 = -1;
  int tx1 = -1;

  // last observed outputs (R10)
  longint last_s0r = 0, last_s0i = 0, last_s1r = 0, last_s1i = 0;
  int     last_l0 = 0, last_l1 = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic longint sat(input longint v);
    if (v > SMAX) return SMAX;
    if (v < SMIN) return SMIN;
    return v;
  endfunction

  // R7/R8 code for one saturated component
  function automatic int slice(input longint v);
    if (v < -2) return 0;
    if (v < 0)  return 1;
    if (v < 2)  return 3;
    return 2;
  endfunction

  function automatic int lvl_of(input int code);
    case (code & 3)
      0: return -3;
      1: return -1;
      2: return 3;
      default: return 1;
    endcase
  endfunction

  task automatic cm(input longint ar, input longint ai, input bit ca,
                    input longint br, input longint bi, input bit cb,
                    output longint pr, output longint pi);
    longint a2, b2;
    a2 = ca ? -ai : ai;
    b2 = cb ? -bi : bi;
    pr = ar * br - a2 * b2;
    pi = ar * b2 + a2 * br;
  endtask

  // noise-free received samples for symbols s0=(a,b), s1=(c,d)
  task automatic make_rx(input int a, input int b, input int c, input int d);
    longint pr, pi, qr, qi;
    // r0 = h0 s0 + h1 s1
    cm(hr[0], hi[0], 0, a, b, 0, pr, pi); cm(hr[1], hi[1], 0, c, d, 0, qr, qi);
    rr[0] = int'(pr + qr); ri[0] = int'(pi + qi);
    // r1 = -h0 conj(s1) + h1 conj(s0)
    cm(hr[0], hi[0], 0, c, d, 1, pr, pi); cm(hr[1], hi[1], 0, a, b, 1, qr, qi);
    rr[1] = int'(qr - pr); ri[1] = int'(qi - pi);
    // r2 = h2 s0 + h3 s1
    cm(hr[2], hi[2], 0, a, b, 0, pr, pi); cm(hr[3], hi[3], 0, c, d, 0, qr, qi);
    rr[2] = int'(pr + qr); ri[2] = int'(pi + qi);
    // r3 = -h2 conj(s1) + h3 conj(s0)
    cm(hr[2], hi[2], 0, c, d, 1, pr, pi); cm(hr[3], hi[3], 0, a, b, 1, qr, qi);
    rr[3] = int'(qr - pr); ri[3] = int'(qi - pi);
  endtask

  task automatic set_h(input int a0, input int b0, input int a1, input int b1,
                       input int a2, input int b2, input int a3, input int b3);
    hr[0] = a0; hi[0] = b0; hr[1] = a1; hi[1] = b1;
    hr[2] = a2; hi[2] = b2; hr[3] = a3; hi[3] = b3;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // drive one pair; gains on slot 0 and during the gap are garbage (R5)
  task automatic send_pair(input int gap);
    longint e0r, e0i, e1r, e1i, pr, pi;
    e0r = 0; e0i = 0; e1r = 0; e1i = 0;
    for (int t = 0; t < 4; t++) begin
      cm(hr[t], hi[t], (t % 2) == 0, rr[t], ri[t], (t % 2) == 1, pr, pi);
      e0r += pr; e0i += pi;
      cm(hr[t ^ 1], hi[t ^ 1], (t % 2) == 0, rr[t], ri[t], (t % 2) == 1, pr, pi);
      if ((t % 2) == 1) begin e1r -= pr; e1i -= pi; end
      else              begin e1r += pr; e1i += pi; end
    end
    ex_s0r[wr] = sat(e0r); ex_s0i[wr] = sat(e0i);
    ex_s1r[wr] = sat(e1r); ex_s1i[wr] = sat(e1i);
    ex_l0[wr]  = slice(ex_s0r[wr]) * 4 + slice(ex_s0i[wr]);
    ex_l1[wr]  = slice(ex_s1r[wr]) * 4 + slice(ex_s1i[wr]);
    ex_tx0[wr] = tx0;
    ex_tx1[wr] = tx1;
    @(negedge clk);
    in_valid = 1'b1;
    rx0_re = SW'(rr[0]); rx0_im = SW'(ri[0]);
    rx1_re = SW'(rr[2]); rx1_im = SW'(ri[2]);
    h0_re = 13; h0_im = -7; h1_re = -19; h1_im = 5;
    h2_re = 9;  h2_im = 22; h3_re = -3;  h3_im = -28;
    for (int i = 0; i < gap; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      rx0_re = 17; rx1_im = -21;
    end
    @(negedge clk);
    in_valid = 1'b1;
    rx0_re = SW'(rr[1]); rx0_im = SW'(ri[1]);
    rx1_re = SW'(rr[3]); rx1_im = SW'(ri[3]);
    h0_re = HW'(hr[0]); h0_im = HW'(hi[0]); h1_re = HW'(hr[1]); h1_im = HW'(hi[1]);
    h2_re = HW'(hr[2]); h2_im = HW'(hi[2]); h3_re = HW'(hr[3]); h3_im = HW'(hi[3]);
    ex_cyc[wr] = cyc + 2;
    wr++;
  endtask

  // output monitor
  always @(negedge clk) begin
    if (!rst_n) begin
      last_s0r = 0; last_s0i = 0; last_s1r = 0; last_s1i = 0;
      last_l0 = 0; last_l1 = 0;
    end else if (out_valid) begin
      if (rd >= wr) begin
        chk(1'b0, "R9 unexpected result", 1, 0);
      end else begin
        chk(cyc == ex_cyc[rd], "R9 latency", cyc, ex_cyc[rd]);
        chk(s0_re == ex_s0r[rd], "R3/R5/R6 s0 real", s0_re, ex_s0r[rd]);
        chk(s0_im == ex_s0i[rd], "R3/R5/R6 s0 imag", s0_im, ex_s0i[rd]);
        chk(s1_re == ex_s1r[rd], "R4/R5/R6 s1 real", s1_re, ex_s1r[rd]);
        chk(s1_im == ex_s1i[rd], "R4/R5/R6 s1 imag", s1_im, ex_s1i[rd]);
        chk(int'(s0_label) == ex_l0[rd], "R7 s0 label", s0_label, ex_l0[rd]);
        chk(int'(s1_label) == ex_l1[rd], "R7 s1 label", s1_label, ex_l1[rd]);
        if (ex_tx0[rd] >= 0) begin
          chk(int'(s0_label) == ex_tx0[rd], "R8 s0 recovered", s0_label, ex_tx0[rd]);
          chk(int'(s1_label) == ex_tx1[rd], "R8 s1 recovered", s1_label, ex_tx1[rd]);
        end
        rd++;
      end
      last_s0r = s0_re; last_s0i = s0_im; last_s1r = s1_re; last_s1i = s1_im;
      last_l0 = s0_label; last_l1 = s1_label;
    end else begin
      chk(s0_re == last_s0r && s0_im == last_s0i && s1_re == last_s1r &&
          s1_im == last_s1i && int'(s0_label) == last_l0 && int'(s1_label) == last_l1,
          "R10 hold", s0_re, last_s0r);
    end
  end

  // sweep every symbol pair through the current channel
  task automatic sweep_symbols(input bit recover, input int gap);
    for (int x = 0; x < 16; x++) begin
      for (int y = 0; y < 16; y++) begin
        make_rx(lvl_of(x >> 2), lvl_of(x), lvl_of(y >> 2), lvl_of(y));
        tx0 = recover ? x : -1;
        tx1 = recover ? y : -1;
        send_pair(gap);
      end
    end
    tx0 = -1; tx1 = -1;
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0;
    rx0_re = 0; rx0_im = 0; rx1_re = 0; rx1_im = 0;
    h0_re = 0; h0_im = 0; h1_re = 0; h1_im = 0;
    h2_re = 0; h2_im = 0; h3_re = 0; h3_im = 0;
    repeat (3) @(negedge clk);
    // R2: reset state
    chk(out_valid == 1'b0, "R2 reset out_valid", out_valid, 0);
    chk(s0_re == 0 && s0_im == 0 && s1_re == 0 && s1_im == 0, "R2 reset estimates", s0_re, 0);
    chk(s0_label == 0 && s1_label == 0, "R2 reset labels", s0_label, 0);
    rst_n = 1'b1;
    idle(2);
    chk(out_valid == 1'b0, "R2 idle after reset", out_valid, 0);

    // R3/R4/R8: single unit paths, back to back
    set_h(1, 0, 0, 0, 0, 0, 0, 0);   sweep_symbols(1'b1, 0);
    set_h(0, 0, 0, 1, 0, 0, 0, 0);   sweep_symbols(1'b1, 0);
    set_h(0, 0, 0, 0, -1, 0, 0, 0);  sweep_symbols(1'b1, 1);
    set_h(0, 0, 0, 0, 0, 0, 0, -1);  sweep_symbols(1'b1, 0);
    // R1: stalls inside a pair, two paths (estimate = 2 s, ties at +/-2)
    set_h(1, 0, 0, 0, 0, 0, 1, 0);   sweep_symbols(1'b0, 3);
    // mixed complex channel
    set_h(1, 1, -1, 0, 0, 1, 1, -1);
    for (int x = 0; x < 16; x++) begin
      make_rx(lvl_of(x >> 2), lvl_of(x), lvl_of(x), lvl_of(x >> 2));
      send_pair(x % 3);
    end
    idle(4);

    // R7: raw estimates across every slicing boundary (s0 = r0, s1 = -conj(r1))
    set_h(1, 0, 0, 0, 0, 0, 0, 0);
    for (int a = -4; a <= 4; a++) begin
      for (int b = -4; b <= 4; b++) begin
        rr[0] = a; ri[0] = b; rr[1] = b; ri[1] = -a;
        rr[2] = 5; ri[2] = -6; rr[3] = -9; ri[3] = 11;
        send_pair(0);
      end
    end
    idle(4);

    // R6: full-scale inputs drive saturation both ways
    set_h(-32, 31, -32, -32, 31, 31, -32, 31);
    for (int k = 0; k < 4; k++) begin rr[k] = -32; ri[k] = (k % 2) ? 31 : -32; end
    send_pair(0);
    for (int k = 0; k < 4; k++) begin rr[k] = 31; ri[k] = (k % 2) ? -32 : 31; end
    send_pair(0);
    set_h(-32, -32, -32, -32, -32, -32, -32, -32);
    for (int k = 0; k < 4; k++) begin rr[k] = -32; ri[k] = -32; end
    send_pair(1);
    idle(6);

    // R2/R1: lone slot-0 sample dropped by reset
    @(negedge clk);
    in_valid = 1'b1; rx0_re = 25; rx0_im = -25; rx1_re = 12; rx1_im = 3;
    @(negedge clk);
    in_valid = 1'b0; rst_n = 1'b0;
    @(negedge clk);
    chk(out_valid == 1'b0 && s0_re == 0 && s1_im == 0, "R2 mid-run reset outputs", s0_re, 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    set_h(0, 1, 0, 0, 0, 0, 0, 0);
    make_rx(3, -1, -3, 1);
    tx0 = 4'b1001; tx1 = 4'b0011;
    send_pair(0);
    tx0 = -1; tx1 = -1;
    idle(6);

    chk(rd == wr, "R9 one result per pair", rd, wr);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errs++;
      $display("FAIL watchdog: actual=%0d expected=%0d", rd, wr);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule